// File: doc/BRIEF.md
# I2C Master Transfer Sequencer

This block runs one whole I2C master transaction, from the opening START to the closing STOP, from a descriptor on its input pins. The descriptor holds a 16-bit address field, a 5-bit shape field, and two byte counts. The shape field picks one of four transaction shapes and can turn on 10-bit addressing. Payload bytes come in on a valid/ready transmit stream and go out on a valid/ready receive stream. The block does not drive SDA or SCL itself. It issues one bus operation at a time (START, repeated START, one bit slot, or STOP) to a separate clock/pin layer. That layer completes each operation with a one-cycle done pulse. With the pulse it returns the SDA level it sampled and flags for lost arbitration or a bus error.

The block reports its progress and result as a signed 3-bit status code. A usage fault is returned at once, with no bus activity, when the shape field is malformed or a receive count is zero. When arbitration is lost, or a bus error occurs, the block stops issuing operations and leaves the pins to the pin layer. It does not retry.

Top module: `i2c_master_seq`

## Requirements
- R1: After reset the status is 0, and op_valid, tx_ready and rx_valid are all low.
- R2: Shape bit 0 (write) issues START, then the address byte with bit 0 = 0, then len0 bytes taken from the transmit stream, then STOP, and ends with status 0. Every byte goes out MSB first as eight bit slots and is followed by a ninth slot driven 1, in which a sampled 0 means ACK. Operation codes are 0 START, 1 repeated START, 2 bit slot, 3 STOP. The op_bit output is 1 for every non-bit operation.
- R3: Shape bit 1 (read) issues START, then the address byte with bit 0 = 1, then reads len0 bytes. Each byte takes eight slots driven 1 and sampled MSB first, then an acknowledge slot driven 0 (ACK), except after the last byte, where the slot is driven 1 (NACK). The block then issues STOP. Each byte appears on rx_data with rx_valid and is held until rx_ready.
- R4: Shape bit 2 (write-read) sends the write address and len0 bytes, then a repeated START, then the read address, then reads len1 bytes, then STOP.
- R5: Shape bit 3 (write-write) sends the write address and then len0+len1 bytes back to back, with no repeated START, then STOP.
- R6: With 7-bit addressing, the address byte is {addr[7:1], R/W}. With shape bit 4 set (10-bit addressing), the block first sends {5'b11110, addr[10:9], 0} and then addr[7:0]. A read then continues with a repeated START and {5'b11110, addr[10:9], 1}.
- R7: A shape field whose bits [3:0] do not hold exactly one set bit, or a zero receive count (len0 for read, len1 for write-read), ends the request with status -4 and issues no bus operation.
- R8: A write count of zero is legal: only START, the address byte and STOP are issued.
- R9: A NACK sampled after an address byte or a written byte is followed at once by STOP and status -1. No further transmit bytes are taken.
- R10: Arbitration lost, reported with a done pulse, ends the transaction with status -3 and no further operation, not even STOP.
- R11: A bus error reported with a done pulse (and no arbitration loss) ends the transaction with status -2 and no further operation.
- R12: After a request is accepted the status is +1 until the transaction ends. A start request while the status is +1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request a transaction with the current descriptor |
| desc_addr | input | 16 | Address field (7-bit in [7:1]; 10-bit in [10:9] and [7:0]) |
| desc_shape | input | 5 | One-hot shape in [3:0]; bit 4 selects 10-bit addressing |
| desc_len0 | input | LEN_W | Byte count of buffer 0 |
| desc_len1 | input | LEN_W | Byte count of buffer 1 |
| tx_data | input | 8 | Transmit byte |
| tx_valid | input | 1 | Transmit byte available |
| tx_ready | output | 1 | Block takes the transmit byte |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | Received byte available |
| rx_ready | input | 1 | Consumer takes the received byte |
| op_valid | output | 1 | Bus operation requested |
| op_code | output | 2 | 0 START, 1 repeated START, 2 bit slot, 3 STOP |
| op_bit | output | 1 | Level to drive in a bit slot (1 = release) |
| op_done | input | 1 | Pin layer finished the operation |
| op_rbit | input | 1 | SDA level sampled in the slot |
| op_arb | input | 1 | Arbitration lost during the operation |
| op_berr | input | 1 | Misplaced START/STOP seen during the operation |
| status | output | 3 | Signed result: +1 busy, 0 done, -1 NACK, -2 bus error, -3 arbitration, -4 usage fault |

## Verification
The sequencer is driven with each of the four shapes using 7-bit addresses. Comparing the repeated-START insertion in write-read against its absence in write-write shows that the two-buffer shapes are told apart. Plain write and plain read with a 10-bit address show the extra address byte and the turnaround address after the repeated START. A zero write count shows that an empty payload is still a complete transaction. Malformed shape fields and zero receive counts must leave the bus untouched. NACKs on an address byte and on a middle data byte, arbitration loss, and a bus error on START each end the transaction on a different path with a different code. A second start pulse during a transfer must leave that transfer undisturbed.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;

  typedef enum logic [1:0] {OP_START = 2'd0, OP_RSTART = 2'd1, OP_BIT = 2'd2, OP_STOP = 2'd3} op_e;

  typedef enum logic [2:0] {PH_S, PH_AW1, PH_AW2, PH_WR, PH_SR, PH_AR, PH_RD, PH_STOP} phase_e;

  typedef enum logic [2:0] {ST_IDLE, ST_LOAD, ST_COND, ST_FETCH, ST_BITS, ST_PUSH} state_e;

  localparam logic [2:0] RC_BUSY  = 3'b001;
  localparam logic [2:0] RC_DONE  = 3'b000;
  localparam logic [2:0] RC_NACK  = 3'b111;
  localparam logic [2:0] RC_BUS   = 3'b110;
  localparam logic [2:0] RC_ARB   = 3'b101;
  localparam logic [2:0] RC_USAGE = 3'b100;

  localparam int SH_WR = 0, SH_RD = 1, SH_WRRD = 2, SH_WRWR = 3, SH_TEN = 4;

  typedef struct packed {
    logic       ten;
    logic       has_rd;
    logic       rd_direct;
    logic [7:0] aw1;
    logic [7:0] aw2;
    logic [7:0] ar;
  } plan_t;

  // First address byte for either addressing width
  function automatic logic [7:0] addr_byte(input logic [15:0] a, input logic ten, input logic rnw);
    return ten ? {5'b11110, a[10:9], rnw} : {a[7:1], rnw};
  endfunction

  // Phase that follows the last write-direction address byte
  function automatic phase_e after_addr(input logic wpend, input logic has_rd);
    if (wpend) return PH_WR;
    return has_rd ? PH_SR : PH_STOP;
  endfunction

endpackage

// File: rtl/i2c_seq_plan.sv
module i2c_seq_plan
  import i2c_seq_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic [15:0]      addr,
  input  logic [4:0]       shape,
  input  logic [LEN_W-1:0] len0,
  input  logic [LEN_W-1:0] len1,
  output plan_t            plan,
  output logic [LEN_W:0]   wlen,
  output logic [LEN_W-1:0] rlen,
  output logic             fault
);
  logic one_hot;

  always_comb begin
    one_hot        = ($countones(shape[3:0]) == 1);
    plan.ten       = shape[SH_TEN];
    plan.has_rd    = shape[SH_RD] | shape[SH_WRRD];
    plan.rd_direct = shape[SH_RD] & ~shape[SH_TEN];
    plan.aw1       = addr_byte(addr, shape[SH_TEN], 1'b0);
    plan.aw2       = addr[7:0];
    plan.ar        = addr_byte(addr, shape[SH_TEN], 1'b1);
    if (shape[SH_WRWR])                    wlen = {1'b0, len0} + {1'b0, len1};
    else if (shape[SH_WR] | shape[SH_WRRD]) wlen = {1'b0, len0};
    else                                   wlen = '0;
    if (shape[SH_RD])        rlen = len0;
    else if (shape[SH_WRRD]) rlen = len1;
    else                     rlen = '0;
    fault = !one_hot || (plan.has_rd && rlen == '0);
  end
endmodule

// File: rtl/i2c_seq_cnt.sv
module i2c_seq_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         more,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (load)           cnt <= load_val;
    else if (dec && cnt != '0) cnt <= cnt - 1'b1;
  end

  assign more = (cnt > W'(1));
  assign zero = (cnt == '0);
endmodule

// File: rtl/i2c_master_seq.sv
module i2c_master_seq
  import i2c_seq_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [15:0]      desc_addr,
  input  logic [4:0]       desc_shape,
  input  logic [LEN_W-1:0] desc_len0,
  input  logic [LEN_W-1:0] desc_len1,
  input  logic [7:0]       tx_data,
  input  logic             tx_valid,
  output logic             tx_ready,
  output logic [7:0]       rx_data,
  output logic             rx_valid,
  input  logic             rx_ready,
  output logic             op_valid,
  output logic [1:0]       op_code,
  output logic             op_bit,
  input  logic             op_done,
  input  logic             op_rbit,
  input  logic             op_arb,
  input  logic             op_berr,
  output logic [2:0]       status
);
  localparam int BITS_PER_BYTE = 8;
  localparam int BIT_W = $clog2(BITS_PER_BYTE + 1);

  state_e           st;
  phase_e           phase, nxt;
  plan_t            plan_d, plan_q;
  logic [LEN_W:0]   wlen_d;
  logic [LEN_W-1:0] rlen_d;
  logic [7:0]       shreg;
  logic [BIT_W-1:0] bitn;
  logic             nack_seen;
  logic             wmore, wzero, rmore, unused_rzero;

  // Named internal events
  logic busy, accept_evt, fault_evt, fire_evt, abort_evt, ack_slot, is_rx, wdec, rdec;

  assign busy       = (status == RC_BUSY);
  assign accept_evt = start && !busy && st == ST_IDLE;
  assign fire_evt   = op_valid && op_done;
  assign abort_evt  = fire_evt && (op_arb || op_berr);
  assign ack_slot   = (st == ST_BITS) && (bitn == BIT_W'(BITS_PER_BYTE));
  assign is_rx      = (phase == PH_RD);
  assign wdec       = ack_slot && fire_evt && !abort_evt && phase == PH_WR && !op_rbit;
  assign rdec       = (st == ST_PUSH) && rx_ready;

  i2c_seq_plan #(.LEN_W(LEN_W)) u_plan (
    .addr(desc_addr), .shape(desc_shape), .len0(desc_len0), .len1(desc_len1),
    .plan(plan_d), .wlen(wlen_d), .rlen(rlen_d), .fault(fault_evt)
  );

  i2c_seq_cnt #(.W(LEN_W + 1)) u_wcnt (
    .clk(clk), .rst_n(rst_n), .load(accept_evt), .load_val(wlen_d),
    .dec(wdec), .more(wmore), .zero(wzero)
  );

  i2c_seq_cnt #(.W(LEN_W)) u_rcnt (
    .clk(clk), .rst_n(rst_n), .load(accept_evt), .load_val(rlen_d),
    .dec(rdec), .more(rmore), .zero(unused_rzero)
  );

  always_comb begin
    case (phase)
      PH_S:    nxt = plan_q.rd_direct ? PH_AR : PH_AW1;
      PH_AW1:  nxt = plan_q.ten ? PH_AW2 : after_addr(!wzero, plan_q.has_rd);
      PH_AW2:  nxt = after_addr(!wzero, plan_q.has_rd);
      PH_WR:   nxt = wmore ? PH_WR : (plan_q.has_rd ? PH_SR : PH_STOP);
      PH_SR:   nxt = PH_AR;
      PH_AR:   nxt = PH_RD;
      PH_RD:   nxt = rmore ? PH_RD : PH_STOP;
      default: nxt = PH_STOP;
    endcase
  end

  always_comb begin
    op_valid = (st == ST_COND) || (st == ST_BITS);
    op_bit   = 1'b1;
    if (st == ST_BITS) begin
      op_code = OP_BIT;
      if (ack_slot) op_bit = is_rx ? !rmore : 1'b1;
      else          op_bit = is_rx ? 1'b1 : shreg[7];
    end else if (phase == PH_S) begin
      op_code = OP_START;
    end else if (phase == PH_SR) begin
      op_code = OP_RSTART;
    end else begin
      op_code = OP_STOP;
    end
  end

  assign tx_ready = (st == ST_FETCH);
  assign rx_valid = (st == ST_PUSH);
  assign rx_data  = shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      phase     <= PH_S;
      plan_q    <= '0;
      shreg     <= '0;
      bitn      <= '0;
      nack_seen <= 1'b0;
      status    <= RC_DONE;
    end else if (abort_evt) begin
      status <= op_arb ? RC_ARB : RC_BUS;
      st     <= ST_IDLE;
    end else begin
      case (st)
        ST_IDLE: if (accept_evt) begin
          if (fault_evt) status <= RC_USAGE;
          else begin
            status    <= RC_BUSY;
            plan_q    <= plan_d;
            phase     <= PH_S;
            nack_seen <= 1'b0;
            st        <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          bitn <= '0;
          case (phase)
            PH_WR:   st <= ST_FETCH;
            PH_AW1:  begin shreg <= plan_q.aw1; st <= ST_BITS; end
            PH_AW2:  begin shreg <= plan_q.aw2; st <= ST_BITS; end
            PH_AR:   begin shreg <= plan_q.ar;  st <= ST_BITS; end
            PH_RD:   st <= ST_BITS;
            default: st <= ST_COND;
          endcase
        end
        ST_COND: if (op_done) begin
          if (phase == PH_STOP) begin
            status <= nack_seen ? RC_NACK : RC_DONE;
            st     <= ST_IDLE;
          end else begin
            phase <= nxt;
            st    <= ST_LOAD;
          end
        end
        ST_FETCH: if (tx_valid) begin
          shreg <= tx_data;
          st    <= ST_BITS;
        end
        ST_BITS: if (op_done) begin
          if (!ack_slot) begin
            shreg <= {shreg[6:0], op_rbit};
            bitn  <= bitn + 1'b1;
          end else if (is_rx) begin
            st <= ST_PUSH;
          end else if (op_rbit) begin
            nack_seen <= 1'b1;
            phase     <= PH_STOP;
            st        <= ST_LOAD;
          end else begin
            phase <= nxt;
            st    <= ST_LOAD;
          end
        end
        ST_PUSH: if (rx_ready) begin
          phase <= nxt;
          st    <= ST_LOAD;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_seq_chk.sv
module i2c_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] status,
  input logic       accept,
  input logic       fault,
  input logic       op_valid,
  input logic [1:0] op_code,
  input logic       op_bit,
  input logic       op_done,
  input logic       op_arb,
  input logic       op_berr,
  input logic       tx_ready,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic [7:0] rx_data
);
  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (status != 3'b001) |-> (!op_valid && !tx_ready && !rx_valid));

  p_usage_fault_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && fault) |=> (status == 3'b100 && !op_valid));

  p_arb_lost_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_done && op_arb) |=> (status == 3'b101 && !op_valid));

  p_bus_err_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_done && op_berr && !op_arb) |=> (status == 3'b110 && !op_valid));

  p_op_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !op_done) |=> (op_valid && $stable(op_code) && $stable(op_bit)));

  p_rx_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

  p_stop_ends_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 3'b001 && op_valid && op_done && op_code != 2'd3 && !op_arb && !op_berr)
      |=> (status == 3'b001));
endmodule

bind i2c_master_seq i2c_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .status(status), .accept(accept_evt), .fault(fault_evt),
  .op_valid(op_valid), .op_code(op_code), .op_bit(op_bit), .op_done(op_done),
  .op_arb(op_arb), .op_berr(op_berr), .tx_ready(tx_ready), .rx_valid(rx_valid),
  .rx_ready(rx_ready), .rx_data(rx_data)
);

// File: tb/test_i2c_master_seq.sv
module test_i2c_master_seq;
  localparam int LW = 8;
  localparam int WD_LIMIT = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          start = 0;
  logic [15:0]   d_addr = 0;
  logic [4:0]    d_shape = 0;
  logic [LW-1:0] d_len0 = 0, d_len1 = 0;
  logic [7:0]    tx_data = 0;
  logic          tx_valid = 0, tx_ready;
  logic [7:0]    rx_data;
  logic          rx_valid;
  logic          rx_ready = 1;
  logic          op_valid, op_bit;
  logic [1:0]    op_code;
  logic          op_done = 0, op_rbit = 0, op_arb = 0, op_berr = 0;
  logic [2:0]    status;

  i2c_master_seq #(.LEN_W(LW)) i_i2c_master_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .desc_addr(d_addr), .desc_shape(d_shape),
    .desc_len0(d_len0), .desc_len1(d_len1), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .op_valid(op_valid), .op_code(op_code), .op_bit(op_bit), .op_done(op_done),
    .op_rbit(op_rbit), .op_arb(op_arb), .op_berr(op_berr), .status(status)
  );

  typedef struct packed {logic [1:0] code; logic bv; logic rb; logic ar; logic be;} item_t;
  item_t      opq[$];
  logic [7:0] txq[$];
  logic [7:0] rxq[$];
  int    checks = 0, errors = 0, cyc = 0;
  bit    pend = 0;
  string cur_req = "R1";

  function automatic int sval();
    return int'($signed(status));
  endfunction

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", cur_req, what, act, exp);
    end
  endtask

  // Scoreboard monitor plus pin-layer responder, all at the falling edge
  always @(negedge clk) begin
    cyc++;
    if (cyc > WD_LIMIT) begin
      errors++;
      $display("FAIL watchdog %s actual=%0d expected=%0d", cur_req, cyc, WD_LIMIT);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
    if (pend && txq.size() > 0) void'(txq.pop_front());
    tx_valid = (txq.size() > 0);
    tx_data  = tx_valid ? txq[0] : 8'h00;
    pend     = tx_valid && tx_ready;
    if (rx_valid) begin
      if (rxq.size() == 0) chk(0, "unexpected rx byte", int'(rx_data), -1);
      else begin
        logic [7:0] e;
        e = rxq.pop_front();
        chk(rx_data == e, "rx byte", int'(rx_data), int'(e));
      end
    end
    if (op_done) begin
      op_done = 0; op_arb = 0; op_berr = 0;
    end else if (op_valid) begin
      if (opq.size() == 0) begin
        chk(0, "unexpected op", int'({op_code, op_bit}), -1);
        op_rbit = 1;
      end else begin
        item_t it;
        it = opq.pop_front();
        chk({op_code, op_bit} == {it.code, it.bv}, "op {code,bit}",
            int'({op_code, op_bit}), int'({it.code, it.bv}));
        op_rbit = it.rb; op_arb = it.ar; op_berr = it.be;
      end
      op_done = 1;
    end
  end

  task automatic e_op(input logic [1:0] c, input logic b, input logic rb, input logic a, input logic be);
    item_t it;
    it = '{code: c, bv: b, rb: rb, ar: a, be: be};
    opq.push_back(it);
  endtask

  task automatic e_tx(input logic [7:0] v, input logic nack);
    for (int i = 7; i >= 0; i--) e_op(2'd2, v[i], v[i], 1'b0, 1'b0);
    e_op(2'd2, 1'b1, nack, 1'b0, 1'b0);
  endtask

  task automatic e_rx(input logic [7:0] v, input logic last);
    for (int i = 7; i >= 0; i--) e_op(2'd2, 1'b1, v[i], 1'b0, 1'b0);
    e_op(2'd2, last, last, 1'b0, 1'b0);
    rxq.push_back(v);
  endtask

  task automatic run(input string req, input logic [15:0] a, input logic [4:0] f,
                     input int l0, input int l1, input int exp, input bit poke);
    int n;
    cur_req = req;
    @(negedge clk);
    d_addr = a; d_shape = f; d_len0 = LW'(l0); d_len1 = LW'(l1); start = 1;
    @(negedge clk);
    start = 0;
    chk(sval() == ((exp == -4) ? -4 : 1), "status after start (R12)", sval(), (exp == -4) ? -4 : 1);
    if (poke) begin
      repeat (6) @(negedge clk);
      d_shape = 5'h02; d_len0 = 0; start = 1;   // would be a usage fault if taken
      @(negedge clk);
      start = 0;
      chk(sval() == 1, "R12 start while busy", sval(), 1);
    end
    n = 0;
    while (sval() == 1 && n < 5000) begin
      @(negedge clk);
      n++;
    end
    repeat (6) @(negedge clk);
    chk(sval() == exp, "final status", sval(), exp);
    chk(opq.size() == 0, "ops not issued", opq.size(), 0);
    chk(rxq.size() == 0, "rx bytes missing", rxq.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(sval() == 0, "R1 status", sval(), 0);
    chk(!op_valid && !tx_ready && !rx_valid, "R1 outputs idle", int'({op_valid, tx_ready, rx_valid}), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R2 plain write, 7-bit address 0x5A
    e_op(0, 1, 1, 0, 0); e_tx(8'hB4, 0); e_tx(8'h3C, 0); e_tx(8'hA5, 0); e_op(3, 1, 1, 0, 0);
    txq.push_back(8'h3C); txq.push_back(8'hA5);
    run("R2", 16'h00B4, 5'h01, 2, 0, 0, 0);
    chk(txq.size() == 0, "R2 tx bytes consumed", txq.size(), 0);

    // R3 plain read of three bytes, last NACKed
    e_op(0, 1, 1, 0, 0); e_tx(8'hB5, 0); e_rx(8'h11, 0); e_rx(8'h22, 0); e_rx(8'h33, 1); e_op(3, 1, 1, 0, 0);
    run("R3", 16'h00B4, 5'h02, 3, 0, 0, 0);

    // R4 write-read with repeated START
    e_op(0, 1, 1, 0, 0); e_tx(8'hB4, 0); e_tx(8'h7E, 0); e_op(1, 1, 1, 0, 0);
    e_tx(8'hB5, 0); e_rx(8'hC1, 0); e_rx(8'h0F, 1); e_op(3, 1, 1, 0, 0);
    txq.push_back(8'h7E);
    run("R4", 16'h00B4, 5'h04, 1, 2, 0, 0);

    // R5 write-write, both buffers back to back
    e_op(0, 1, 1, 0, 0); e_tx(8'hB4, 0); e_tx(8'h01, 0); e_tx(8'h02, 0); e_tx(8'h03, 0); e_op(3, 1, 1, 0, 0);
    txq.push_back(8'h01); txq.push_back(8'h02); txq.push_back(8'h03);
    run("R5", 16'h00B4, 5'h08, 2, 1, 0, 0);

    // R6 10-bit write to 0x2C3
    e_op(0, 1, 1, 0, 0); e_tx(8'hF2, 0); e_tx(8'hC3, 0); e_tx(8'h99, 0); e_op(3, 1, 1, 0, 0);
    txq.push_back(8'h99);
    run("R6 write", 16'h02C3, 5'h11, 1, 0, 0, 0);

    // R6 10-bit read: full write address, repeated START, upper byte with read bit
    e_op(0, 1, 1, 0, 0); e_tx(8'hF2, 0); e_tx(8'hC3, 0); e_op(1, 1, 1, 0, 0);
    e_tx(8'hF3, 0); e_rx(8'h5A, 1); e_op(3, 1, 1, 0, 0);
    run("R6 read", 16'h02C3, 5'h12, 1, 0, 0, 0);

    // R8 zero-length write
    e_op(0, 1, 1, 0, 0); e_tx(8'hB4, 0); e_op(3, 1, 1, 0, 0);
    run("R8", 16'h00B4, 5'h01, 0, 0, 0, 0);

    // R7 usage faults: no bus operation expected
    run("R7 read len 0", 16'h00B4, 5'h02, 0, 3, -4, 0);
    run("R7 write-read len1 0", 16'h00B4, 5'h04, 2, 0, -4, 0);
    run("R7 two shape bits", 16'h00B4, 5'h03, 1, 1, -4, 0);
    run("R7 no shape bit", 16'h00B4, 5'h10, 1, 1, -4, 0);

    // R9 NACK on address
    e_op(0, 1, 1, 0, 0); e_tx(8'hB4, 1); e_op(3, 1, 1, 0, 0);
    run("R9 addr", 16'h00B4, 5'h01, 0, 0, -1, 0);

    // R9 NACK on second of three data bytes
    e_op(0, 1, 1, 0, 0); e_tx(8'hB4, 0); e_tx(8'h10, 0); e_tx(8'h20, 1); e_op(3, 1, 1, 0, 0);
    txq.push_back(8'h10); txq.push_back(8'h20); txq.push_back(8'h30);
    run("R9 data", 16'h00B4, 5'h01, 3, 0, -1, 0);
    chk(txq.size() == 1, "R9 remaining tx byte untouched", txq.size(), 1);
    txq.delete();
    repeat (2) @(negedge clk);

    // R10 arbitration lost on first address bit: no STOP may follow
    e_op(0, 1, 1, 0, 0); e_op(2, 1, 0, 1, 0);
    run("R10", 16'h00B4, 5'h01, 0, 0, -3, 0);

    // R11 bus error reported on START
    e_op(0, 1, 1, 0, 1);
    run("R11", 16'h00B4, 5'h01, 0, 0, -2, 0);

    // R12 start pulse during a transfer is ignored
    e_op(0, 1, 1, 0, 0); e_tx(8'hB4, 0); e_tx(8'h66, 0); e_op(3, 1, 1, 0, 0);
    txq.push_back(8'h66);
    run("R12", 16'h00B4, 5'h01, 1, 0, 0, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule